// File: doc/BRIEF.md
# Renaming Issue Cluster with Shared Result Bus

This block sits between an in-order instruction source and a set of execution units: an add/sub unit with two waiting slots, and a multiply unit, a divide unit and a load unit with one slot each. Each issued instruction takes a free slot in its unit's group. At that moment each of its two sources is resolved either to a committed register value or to the tag of the slot that will later produce it. The destination register is then renamed to the new slot's tag. A slot whose two operands are both present is handed to its unit. Each unit later returns its result together with the producer tag. One result per cycle wins a fixed-priority arbiter and is broadcast. Every slot waiting on that tag takes the value directly from the broadcast. The register file keeps the value only if the register still names that producer.

Because sources are captured or renamed at issue, write-after-read and write-after-write conflicts never cause a stall. Only a full slot group holds up issue. A read port exposes each register's committed value and its pending producer tag. The units themselves are outside the block. The block offers dispatch only to a unit that signals it can take work, and a unit that loses the broadcast arbitration keeps presenting its result.

Top module: `rs_cluster`

## Requirements
- R1: While `iss_valid` is high and every slot of the group selected by `iss_unit` is occupied, `iss_stall` is high and `iss_tag` is 0. No slot is taken and no register is renamed. Otherwise `iss_stall` is low.
- R2: A source whose register tag is 0 is copied into the slot at issue. It appears on `dsp_opa` (first source) or `dsp_opb` (second source), and the opcode on `dsp_op`, when the slot is dispatched.
- R3: A source whose register tag is non-zero records that tag. The slot is not offered for dispatch until every recorded tag has been matched by a broadcast. The matched value then appears as that operand.
- R4: `dsp_valid[u]` is high only while `unit_ready[u]` is high and a slot of unit u holds both operands and has not yet been dispatched. Among such slots, the lowest tag is offered. A slot is dispatched at most once.
- R5: When several units raise `res_valid`, the lowest unit index is granted on `res_grant` (one-hot) and drives `cdb_tag`/`cdb_data` with `cdb_valid` high. Units that are not granted are not consumed.
- R6: A broadcast updates a register's value only when that register's tag equals the broadcast tag. A result from an older producer of a renamed register is discarded.
- R7: An accepted issue sets the destination register's tag to the new slot's tag. A broadcast of that tag clears it to 0 and stores the value.
- R8: If a source register's tag is broadcast in the same cycle as an issue reads it, the slot stores the broadcast value as present, not the tag.
- R9: An instruction writing a register that an earlier waiting slot reads issues without stall. The earlier slot still dispatches the old value.
- R10: After reset no slot is occupied, every register reads value 0 and tag 0, `dsp_valid` is 0 and `cdb_valid` is 0.
- R11: Slot tags are fixed per unit: unit code 0 (add/sub) owns tags 1 and 2, unit code 1 (multiply) owns tag 3, unit code 2 (divide) owns tag 4, unit code 3 (load) owns tag 5. Issue takes the lowest free tag of the group. A slot becomes free after its own tag is broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_unit | input | 2 | Target unit code |
| iss_op | input | 4 | Opcode passed through to the unit |
| iss_dst | input | 4 | Destination register |
| iss_src1 | input | 4 | First source register |
| iss_src2 | input | 4 | Second source register |
| iss_stall | output | 1 | Issue held: target group full |
| iss_tag | output | 3 | Tag given to the accepted issue, 0 when none |
| unit_ready | input | 4 | Per unit: can accept a dispatch this cycle |
| dsp_valid | output | 4 | Per unit: a slot is handed over this cycle |
| dsp_tag | output | 12 | Per unit 3-bit producer tag of the dispatched slot |
| dsp_op | output | 16 | Per unit 4-bit opcode |
| dsp_opa | output | 128 | Per unit 32-bit first operand |
| dsp_opb | output | 128 | Per unit 32-bit second operand |
| res_valid | input | 4 | Per unit: result waiting to be broadcast |
| res_tag | input | 12 | Per unit 3-bit producer tag of the result |
| res_data | input | 128 | Per unit 32-bit result value |
| res_grant | output | 4 | One-hot grant of the broadcast bus |
| cdb_valid | output | 1 | Broadcast active |
| cdb_tag | output | 3 | Broadcast producer tag |
| cdb_data | output | 32 | Broadcast value |
| rd_addr | input | 4 | Register read select |
| rd_data | output | 32 | Committed value of the selected register |
| rd_tag | output | 3 | Pending producer tag of the selected register, 0 when committed |

## Verification
The assertions assume the units behave sanely. A unit returns only tags that it was handed, and only after the dispatch cycle. Such a tag is therefore always held by an occupied slot when it reaches the bus. The bench acts as every unit itself. It raises `unit_ready` only when it wants a slot. It returns each result a cycle or more later, carrying the tag it read from `dsp_tag`. It never sends a tag twice, so the assumptions hold by construction. Register 0 is never used as a destination, so loads, whose sources are register 0, are always ready at once.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned TAG_W     = 3;
    localparam int unsigned OP_W      = 4;
    localparam int unsigned NUM_UNITS = 4;
    localparam int unsigned UNIT_W    = $clog2(NUM_UNITS);

    // slots per unit: add/sub, multiply, divide, load
    localparam int unsigned SLOTS [NUM_UNITS] = '{2, 1, 1, 1};

    function automatic int unsigned slot_base(input int unsigned u);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < NUM_UNITS; i++) begin
            if (i < u) acc += SLOTS[i];
        end
        return acc;
    endfunction

    localparam int unsigned NUM_ST = slot_base(NUM_UNITS);

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  qa;
        logic [TAG_W-1:0]  qb;
        logic [DATA_W-1:0] va;
        logic [DATA_W-1:0] vb;
    } slot_t;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         hit
);

    always_comb begin
        gnt = '0;
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !hit) begin
                gnt[i] = 1'b1;
                hit    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_cdb_arb.sv
module rs_cdb_arb
    import rs_pkg::*;
(
    input  logic [NUM_UNITS-1:0]        res_valid,
    input  logic [NUM_UNITS*TAG_W-1:0]  res_tag,
    input  logic [NUM_UNITS*DATA_W-1:0] res_data,
    output logic [NUM_UNITS-1:0]        res_grant,
    output logic                        cdb_valid,
    output logic [TAG_W-1:0]            cdb_tag,
    output logic [DATA_W-1:0]           cdb_data
);

    rs_pick #(.N(NUM_UNITS)) u_pick (
        .req (res_valid),
        .gnt (res_grant),
        .hit (cdb_valid)
    );

    always_comb begin
        cdb_tag  = '0;
        cdb_data = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (res_grant[u]) begin
                cdb_tag  = res_tag[u*TAG_W +: TAG_W];
                cdb_data = res_data[u*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/rs_regstate.sv
module rs_regstate
    import rs_pkg::*;
#(
    parameter  int unsigned NUM_REGS = 16,
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ren_en,
    input  logic [REG_W-1:0]                 ren_reg,
    input  logic [TAG_W-1:0]                 ren_tag,
    input  logic                             bc_hit,
    input  logic [TAG_W-1:0]                 bc_tag,
    input  logic [DATA_W-1:0]                bc_data,
    input  logic [REG_W-1:0]                 src1,
    input  logic [REG_W-1:0]                 src2,
    output logic [TAG_W-1:0]                 s1_tag,
    output logic [DATA_W-1:0]                s1_val,
    output logic [TAG_W-1:0]                 s2_tag,
    output logic [DATA_W-1:0]                s2_val,
    input  logic [REG_W-1:0]                 rd_addr,
    output logic [TAG_W-1:0]                 rd_tag,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_REGS-1:0][TAG_W-1:0]   tag_all,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  val_all
);

    typedef struct packed {
        logic [NUM_REGS-1:0][TAG_W-1:0]  tag;
        logic [NUM_REGS-1:0][DATA_W-1:0] val;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    // next state: broadcast commit first, rename overrides the tag
    always_comb begin
        rf_d = rf_q;
        if (bc_hit) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (rf_q.tag[r] == bc_tag) begin
                    rf_d.val[r] = bc_data;
                    rf_d.tag[r] = '0;
                end
            end
        end
        if (ren_en) rf_d.tag[ren_reg] = ren_tag;
    end

    // source lookup with same-cycle broadcast bypass
    always_comb begin
        s1_tag = rf_q.tag[src1];
        s1_val = rf_q.val[src1];
        if (s1_tag != '0) begin
            if (bc_hit && bc_tag == s1_tag) begin
                s1_tag = '0;
                s1_val = bc_data;
            end else begin
                s1_val = '0;
            end
        end
        s2_tag = rf_q.tag[src2];
        s2_val = rf_q.val[src2];
        if (s2_tag != '0) begin
            if (bc_hit && bc_tag == s2_tag) begin
                s2_tag = '0;
                s2_val = bc_data;
            end else begin
                s2_val = '0;
            end
        end
    end

    assign rd_tag  = rf_q.tag[rd_addr];
    assign rd_data = rf_q.val[rd_addr];
    assign tag_all = rf_q.tag;
    assign val_all = rf_q.val;

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

endmodule

// File: rtl/rs_cluster.sv
module rs_cluster
    import rs_pkg::*;
#(
    parameter  int unsigned NUM_REGS = 16,
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [UNIT_W-1:0]           iss_unit,
    input  logic [OP_W-1:0]             iss_op,
    input  logic [REG_W-1:0]            iss_dst,
    input  logic [REG_W-1:0]            iss_src1,
    input  logic [REG_W-1:0]            iss_src2,
    output logic                        iss_stall,
    output logic [TAG_W-1:0]            iss_tag,
    input  logic [NUM_UNITS-1:0]        unit_ready,
    output logic [NUM_UNITS-1:0]        dsp_valid,
    output logic [NUM_UNITS*TAG_W-1:0]  dsp_tag,
    output logic [NUM_UNITS*OP_W-1:0]   dsp_op,
    output logic [NUM_UNITS*DATA_W-1:0] dsp_opa,
    output logic [NUM_UNITS*DATA_W-1:0] dsp_opb,
    input  logic [NUM_UNITS-1:0]        res_valid,
    input  logic [NUM_UNITS*TAG_W-1:0]  res_tag,
    input  logic [NUM_UNITS*DATA_W-1:0] res_data,
    output logic [NUM_UNITS-1:0]        res_grant,
    output logic                        cdb_valid,
    output logic [TAG_W-1:0]            cdb_tag,
    output logic [DATA_W-1:0]           cdb_data,
    input  logic [REG_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [TAG_W-1:0]            rd_tag
);

    typedef struct packed {
        slot_t [NUM_ST-1:0] st;
    } cl_state_t;

    cl_state_t s_d, s_q;

    logic [NUM_UNITS-1:0][NUM_ST-1:0] free_oh;
    logic [NUM_UNITS-1:0][NUM_ST-1:0] disp_oh;
    logic [NUM_UNITS-1:0]             free_any;
    logic [NUM_ST-1:0]                alloc_oh;
    logic [NUM_ST-1:0]                disp_any;
    logic [NUM_ST-1:0]                st_busy;
    logic                             iss_fire;
    logic                             bc_hit;
    logic [TAG_W-1:0]                 s1_tag, s2_tag;
    logic [DATA_W-1:0]                s1_val, s2_val;
    logic [NUM_REGS-1:0][TAG_W-1:0]   rf_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0]  rf_val;

    // ---------------- broadcast bus ----------------
    rs_cdb_arb u_arb (
        .res_valid (res_valid),
        .res_tag   (res_tag),
        .res_data  (res_data),
        .res_grant (res_grant),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data)
    );

    assign bc_hit = cdb_valid && (cdb_tag != '0);

    // ---------------- per-unit slot selection ----------------
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam int unsigned BASE = slot_base(u);
        localparam int unsigned CNT  = SLOTS[u];

        logic [CNT-1:0] free_req, free_gnt, rdy_req, rdy_gnt;
        logic           free_hit, rdy_hit;

        always_comb begin
            for (int i = 0; i < CNT; i++) begin
                free_req[i] = !s_q.st[BASE+i].busy;
                rdy_req[i]  = s_q.st[BASE+i].busy && !s_q.st[BASE+i].sent &&
                              (s_q.st[BASE+i].qa == '0) && (s_q.st[BASE+i].qb == '0);
            end
        end

        rs_pick #(.N(CNT)) u_free (.req(free_req), .gnt(free_gnt), .hit(free_hit));
        rs_pick #(.N(CNT)) u_rdy  (.req(rdy_req),  .gnt(rdy_gnt),  .hit(rdy_hit));

        assign free_oh[u]   = NUM_ST'(free_gnt) << BASE;
        assign free_any[u]  = free_hit;
        assign dsp_valid[u] = unit_ready[u] && rdy_hit;
        assign disp_oh[u]   = dsp_valid[u] ? (NUM_ST'(rdy_gnt) << BASE) : '0;
    end

    // ---------------- issue ----------------
    assign iss_fire  = iss_valid && free_any[iss_unit];
    assign iss_stall = iss_valid && !free_any[iss_unit];
    assign alloc_oh  = iss_fire ? free_oh[iss_unit] : '0;

    always_comb begin
        iss_tag = '0;
        for (int s = 0; s < NUM_ST; s++) begin
            if (alloc_oh[s]) iss_tag = TAG_W'(s + 1);
        end
    end

    rs_regstate #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ren_en  (iss_fire),
        .ren_reg (iss_dst),
        .ren_tag (iss_tag),
        .bc_hit  (bc_hit),
        .bc_tag  (cdb_tag),
        .bc_data (cdb_data),
        .src1    (iss_src1),
        .src2    (iss_src2),
        .s1_tag  (s1_tag),
        .s1_val  (s1_val),
        .s2_tag  (s2_tag),
        .s2_val  (s2_val),
        .rd_addr (rd_addr),
        .rd_tag  (rd_tag),
        .rd_data (rd_data),
        .tag_all (rf_tag),
        .val_all (rf_val)
    );

    // ---------------- dispatch outputs ----------------
    always_comb begin
        disp_any = '0;
        dsp_tag  = '0;
        dsp_op   = '0;
        dsp_opa  = '0;
        dsp_opb  = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            disp_any = disp_any | disp_oh[u];
            for (int s = 0; s < NUM_ST; s++) begin
                if (disp_oh[u][s]) begin
                    dsp_tag[u*TAG_W +: TAG_W]   = TAG_W'(s + 1);
                    dsp_op[u*OP_W +: OP_W]      = s_q.st[s].op;
                    dsp_opa[u*DATA_W +: DATA_W] = s_q.st[s].va;
                    dsp_opb[u*DATA_W +: DATA_W] = s_q.st[s].vb;
                end
            end
        end
    end

    // ---------------- slot next state ----------------
    always_comb begin
        s_d = s_q;
        for (int s = 0; s < NUM_ST; s++) begin
            st_busy[s] = s_q.st[s].busy;
            if (bc_hit && s_q.st[s].busy) begin
                if (s_q.st[s].qa == cdb_tag) begin
                    s_d.st[s].qa = '0;
                    s_d.st[s].va = cdb_data;
                end
                if (s_q.st[s].qb == cdb_tag) begin
                    s_d.st[s].qb = '0;
                    s_d.st[s].vb = cdb_data;
                end
            end
            if (disp_any[s]) s_d.st[s].sent = 1'b1;
            if (bc_hit && cdb_tag == TAG_W'(s + 1)) begin
                s_d.st[s].busy = 1'b0;
                s_d.st[s].sent = 1'b0;
            end
            if (alloc_oh[s]) begin
                s_d.st[s].busy = 1'b1;
                s_d.st[s].sent = 1'b0;
                s_d.st[s].op   = iss_op;
                s_d.st[s].qa   = s1_tag;
                s_d.st[s].va   = s1_val;
                s_d.st[s].qb   = s2_tag;
                s_d.st[s].vb   = s2_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rs_cluster_chk.sv
module rs_cluster_chk
    import rs_pkg::*;
#(
    parameter  int unsigned NUM_REGS = 16,
    localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            iss_valid,
    input logic                            iss_stall,
    input logic                            iss_fire,
    input logic [TAG_W-1:0]                iss_tag,
    input logic [REG_W-1:0]                iss_dst,
    input logic [NUM_ST-1:0]               st_busy,
    input logic [NUM_UNITS-1:0]            res_valid,
    input logic [NUM_UNITS-1:0]            res_grant,
    input logic                            cdb_valid,
    input logic [TAG_W-1:0]                cdb_tag,
    input logic [DATA_W-1:0]               cdb_data,
    input logic [NUM_UNITS-1:0]            dsp_valid,
    input logic [NUM_UNITS*TAG_W-1:0]      dsp_tag,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  rf_tag,
    input logic [NUM_REGS-1:0][DATA_W-1:0] rf_val
);

    localparam int unsigned TAGS = 1 << TAG_W;

    logic [TAGS-1:0] busy_by_tag;
    assign busy_by_tag = {{(TAGS - NUM_ST - 1){1'b0}}, st_busy, 1'b0};

    assert_stall_only_on_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> (iss_valid && !iss_fire));

    assert_slot_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |=> busy_by_tag[$past(iss_tag)]);

    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_grant));

    assert_bus_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|res_valid) |-> (cdb_valid && $countones(res_grant & res_valid) == 1));

    assert_bus_tag_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> busy_by_tag[cdb_tag]);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        assert_no_redispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dsp_valid[u] |=>
                !(dsp_valid[u] && dsp_tag[u*TAG_W +: TAG_W] == $past(dsp_tag[u*TAG_W +: TAG_W])));
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
        assert_commit_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && rf_tag[r] == cdb_tag && !(iss_fire && iss_dst == REG_W'(r)))
            |=> (rf_tag[r] == '0 && rf_val[r] == $past(cdb_data)));

        assert_commit_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(cdb_valid && rf_tag[r] == cdb_tag) |=> $stable(rf_val[r]));

        assert_rename_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_fire && iss_dst == REG_W'(r)) |=> rf_tag[r] == $past(iss_tag));
    end

endmodule

bind rs_cluster rs_cluster_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_stall (iss_stall),
    .iss_fire  (iss_fire),
    .iss_tag   (iss_tag),
    .iss_dst   (iss_dst),
    .st_busy   (st_busy),
    .res_valid (res_valid),
    .res_grant (res_grant),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_data  (cdb_data),
    .dsp_valid (dsp_valid),
    .dsp_tag   (dsp_tag),
    .rf_tag    (rf_tag),
    .rf_val    (rf_val)
);

// File: tb/test_rs_cluster.sv
module test_rs_cluster;

    localparam int NU = 4;
    localparam int TW = 3;
    localparam int DW = 32;
    localparam logic [1:0] U_ADD = 2'd0, U_MUL = 2'd1, U_DIV = 2'd2, U_LD = 2'd3;
    localparam logic [3:0] OP_ADD = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3, OP_LD = 4'h4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid;
    logic [1:0]    iss_unit;
    logic [3:0]    iss_op, iss_dst, iss_src1, iss_src2;
    logic          iss_stall;
    logic [2:0]    iss_tag;
    logic [NU-1:0] unit_ready, dsp_valid, res_valid, res_grant;
    logic [NU*TW-1:0] dsp_tag, res_tag;
    logic [NU*4-1:0]  dsp_op;
    logic [NU*DW-1:0] dsp_opa, dsp_opb, res_data;
    logic          cdb_valid;
    logic [2:0]    cdb_tag, rd_tag;
    logic [31:0]   cdb_data, rd_data;
    logic [3:0]    rd_addr = 4'd0;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_rf [16];

    always #2 clk = ~clk;

    rs_cluster i_rs_cluster (.*);

    // dst, src1, src2, a, b
    localparam logic [75:0] VEC [6] = '{
        {4'd5, 4'd1, 4'd2, 32'h0000_0011, 32'h0000_0022},
        {4'd6, 4'd3, 4'd4, 32'hFFFF_FFFF, 32'h0000_0001},
        {4'd7, 4'd2, 4'd1, 32'h1234_5678, 32'h0F0F_0F0F},
        {4'd8, 4'd4, 4'd3, 32'h8000_0000, 32'h8000_0000},
        {4'd9, 4'd1, 4'd3, 32'hDEAD_0000, 32'h0000_BEEF},
        {4'd3, 4'd2, 4'd4, 32'h0000_0100, 32'h0000_0200}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        iss_valid  = 1'b0;
        iss_unit   = 2'd0;
        iss_op     = 4'd0;
        iss_dst    = 4'd0;
        iss_src1   = 4'd0;
        iss_src2   = 4'd0;
        unit_ready = '0;
        res_valid  = '0;
        res_tag    = '0;
        res_data   = '0;
    endtask

    task automatic idle();
        @(negedge clk);
        clr();
        #1;
    endtask

    task automatic issue(input logic [1:0] u, input logic [3:0] op, input logic [3:0] d,
                         input logic [3:0] a, input logic [3:0] b,
                         output logic [2:0] tag, output logic stall);
        @(negedge clk);
        clr();
        iss_valid = 1'b1; iss_unit = u; iss_op = op;
        iss_dst = d; iss_src1 = a; iss_src2 = b;
        #1;
        tag = iss_tag;
        stall = iss_stall;
    endtask

    task automatic disp(input logic [1:0] u, output logic v, output logic [2:0] tag,
                        output logic [3:0] op, output logic [31:0] a, output logic [31:0] b);
        @(negedge clk);
        clr();
        unit_ready[u] = 1'b1;
        #1;
        v   = dsp_valid[u];
        tag = dsp_tag[u*TW +: TW];
        op  = dsp_op[u*4 +: 4];
        a   = dsp_opa[u*DW +: DW];
        b   = dsp_opb[u*DW +: DW];
    endtask

    task automatic put_res(input logic [1:0] u, input logic [2:0] tag, input logic [31:0] d);
        res_valid[u] = 1'b1;
        res_tag[u*TW +: TW] = tag;
        res_data[u*DW +: DW] = d;
    endtask

    task automatic bcast(input logic [1:0] u, input logic [2:0] tag, input logic [31:0] d);
        @(negedge clk);
        clr();
        put_res(u, tag, d);
        #1;
    endtask

    task automatic rd(input logic [3:0] r, output logic [2:0] t, output logic [31:0] d);
        rd_addr = r;
        #1;
        t = rd_tag;
        d = rd_data;
    endtask

    task automatic load_reg(input logic [3:0] r, input logic [31:0] val);
        logic [2:0] t, dt;
        logic s, v;
        logic [3:0] op;
        logic [31:0] a, b;
        issue(U_LD, OP_LD, r, 4'd0, 4'd0, t, s);
        chk("R11", "load slot tag", {29'd0, t}, 32'd5);
        disp(U_LD, v, dt, op, a, b);
        chk("R2", "load dispatched", {31'd0, v}, 32'd1);
        bcast(U_LD, dt, val);
        idle();
        exp_rf[r] = val;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [2:0]  t, t2, dt;
        logic [3:0]  op;
        logic        s, v;
        logic [31:0] a, b, rv;
        logic [75:0] vec;

        for (int i = 0; i < 16; i++) exp_rf[i] = 32'd0;
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // ---- R10: reset state ----
        @(negedge clk);
        unit_ready = '1;
        #1;
        chk("R10", "dsp_valid", {28'd0, dsp_valid}, 32'd0);
        chk("R10", "cdb_valid", {31'd0, cdb_valid}, 32'd0);
        chk("R10", "iss_stall", {31'd0, iss_stall}, 32'd0);
        for (int r = 0; r < 16; r += 5) begin
            rd(4'(r), t, rv);
            chk("R10", "reg tag", {29'd0, t}, 32'd0);
            chk("R10", "reg value", rv, 32'd0);
        end

        // ---- table: load two sources, add, commit ----
        for (int i = 0; i < 6; i++) begin
            vec = VEC[i];
            load_reg(vec[71:68], vec[63:32]);
            load_reg(vec[67:64], vec[31:0]);
            issue(U_ADD, OP_ADD, vec[75:72], vec[71:68], vec[67:64], t, s);
            chk("R11", "add slot tag", {29'd0, t}, 32'd1);
            idle();
            rd(vec[75:72], t2, rv);
            chk("R7", "renamed tag", {29'd0, t2}, 32'd1);
            disp(U_ADD, v, dt, op, a, b);
            chk("R2", "dispatch valid", {31'd0, v}, 32'd1);
            chk("R2", "dispatch op", {28'd0, op}, {28'd0, OP_ADD});
            chk("R2", "operand a", a, vec[63:32]);
            chk("R2", "operand b", b, vec[31:0]);
            bcast(U_ADD, dt, a + b);
            idle();
            exp_rf[vec[75:72]] = vec[63:32] + vec[31:0];
            rd(vec[75:72], t2, rv);
            chk("R7", "tag cleared", {29'd0, t2}, 32'd0);
            chk("R7", "committed value", rv, exp_rf[vec[75:72]]);
        end

        // ---- R1 / R3 / R4 / R5 ----
        issue(U_LD, OP_LD, 4'd5, 4'd0, 4'd0, t, s);
        chk("R11", "load tag", {29'd0, t}, 32'd5);
        issue(U_ADD, OP_ADD, 4'd6, 4'd5, 4'd1, t, s);
        chk("R11", "first add tag", {29'd0, t}, 32'd1);
        issue(U_ADD, OP_ADD, 4'd7, 4'd1, 4'd5, t, s);
        chk("R11", "second add tag", {29'd0, t}, 32'd2);
        issue(U_ADD, OP_ADD, 4'd8, 4'd1, 4'd2, t, s);
        chk("R1", "stall when full", {31'd0, s}, 32'd1);
        chk("R1", "no tag when full", {29'd0, t}, 32'd0);
        idle();
        rd(4'd8, t2, rv);
        chk("R1", "no rename when stalled", {29'd0, t2}, 32'd0);
        issue(U_MUL, OP_MUL, 4'd9, 4'd1, 4'd2, t, s);
        chk("R1", "other group free", {31'd0, s}, 32'd0);
        chk("R11", "mul tag", {29'd0, t}, 32'd3);
        disp(U_ADD, v, dt, op, a, b);
        chk("R3", "no dispatch while pending", {31'd0, v}, 32'd0);
        disp(U_LD, v, dt, op, a, b);
        bcast(U_LD, dt, 32'h0000_A5A5);
        idle();
        exp_rf[5] = 32'h0000_A5A5;
        disp(U_ADD, v, dt, op, a, b);
        chk("R4", "lowest ready tag", {29'd0, dt}, 32'd1);
        chk("R3", "captured first operand", a, 32'h0000_A5A5);
        chk("R3", "held second operand", b, exp_rf[1]);
        disp(U_ADD, v, dt, op, a, b);
        chk("R4", "next ready tag", {29'd0, dt}, 32'd2);
        chk("R3", "captured second operand", b, 32'h0000_A5A5);
        disp(U_MUL, v, dt, op, a, b);
        chk("R2", "mul dispatched", {29'd0, dt}, 32'd3);
        @(negedge clk);
        clr();
        put_res(U_ADD, 3'd1, 32'h0000_1111);
        put_res(U_MUL, 3'd3, 32'h0000_3333);
        #1;
        chk("R5", "grant lowest unit", {28'd0, res_grant}, 32'd1);
        chk("R5", "bus tag", {29'd0, cdb_tag}, 32'd1);
        bcast(U_MUL, 3'd3, 32'h0000_3333);
        chk("R5", "loser granted later", {28'd0, res_grant}, 32'd2);
        bcast(U_ADD, 3'd2, 32'h0000_2222);
        idle();
        rd(4'd6, t2, rv);
        chk("R5", "winner committed", rv, 32'h0000_1111);
        rd(4'd9, t2, rv);
        chk("R5", "loser committed", rv, 32'h0000_3333);
        rd(4'd7, t2, rv);
        chk("R5", "third committed", rv, 32'h0000_2222);

        // ---- R6 / R7: two writers of one register ----
        issue(U_ADD, OP_ADD, 4'd10, 4'd1, 4'd2, t, s);
        issue(U_MUL, OP_MUL, 4'd10, 4'd1, 4'd2, t, s);
        idle();
        rd(4'd10, t2, rv);
        chk("R7", "latest producer tag", {29'd0, t2}, 32'd3);
        disp(U_ADD, v, dt, op, a, b);
        disp(U_MUL, v, dt, op, a, b);
        bcast(U_MUL, 3'd3, 32'h0000_0777);
        idle();
        rd(4'd10, t2, rv);
        chk("R6", "newer result kept", rv, 32'h0000_0777);
        bcast(U_ADD, 3'd1, 32'h0000_0999);
        idle();
        rd(4'd10, t2, rv);
        chk("R6", "older result discarded", rv, 32'h0000_0777);
        chk("R6", "tag stays clear", {29'd0, t2}, 32'd0);

        // ---- R9: write-after-read issues at once ----
        issue(U_LD, OP_LD, 4'd12, 4'd0, 4'd0, t, s);
        issue(U_DIV, OP_DIV, 4'd11, 4'd12, 4'd13, t, s);
        chk("R11", "div tag", {29'd0, t}, 32'd4);
        issue(U_ADD, OP_ADD, 4'd13, 4'd1, 4'd2, t, s);
        chk("R9", "no stall on overwrite", {31'd0, s}, 32'd0);
        disp(U_ADD, v, dt, op, a, b);
        bcast(U_ADD, dt, 32'h0000_1313);
        idle();
        rd(4'd13, t2, rv);
        chk("R9", "new value committed", rv, 32'h0000_1313);
        disp(U_LD, v, dt, op, a, b);
        bcast(U_LD, dt, 32'h0000_1212);
        idle();
        disp(U_DIV, v, dt, op, a, b);
        chk("R9", "div dispatched", {31'd0, v}, 32'd1);
        chk("R9", "div first operand", a, 32'h0000_1212);
        chk("R9", "div keeps old value", b, exp_rf[13]);
        bcast(U_DIV, dt, 32'h0000_0001);
        idle();

        // ---- R8: broadcast and issue in the same cycle ----
        issue(U_LD, OP_LD, 4'd14, 4'd0, 4'd0, t, s);
        disp(U_LD, v, dt, op, a, b);
        @(negedge clk);
        clr();
        iss_valid = 1'b1; iss_unit = U_ADD; iss_op = OP_ADD;
        iss_dst = 4'd15; iss_src1 = 4'd14; iss_src2 = 4'd1;
        put_res(U_LD, 3'd5, 32'h0000_B0B0);
        #1;
        chk("R8", "issue accepted", {31'd0, iss_stall}, 32'd0);
        idle();
        rd(4'd14, t2, rv);
        chk("R8", "source committed", rv, 32'h0000_B0B0);
        disp(U_ADD, v, dt, op, a, b);
        chk("R8", "bypass dispatch ready", {31'd0, v}, 32'd1);
        chk("R8", "bypassed operand", a, 32'h0000_B0B0);
        chk("R8", "second operand", b, exp_rf[1]);
        bcast(U_ADD, dt, 32'h0);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule